// File: doc/BRIEF.md
# Bouncing Target Catch Game

A single lit position travels along a row of LEDs. It holds each position for a fixed number of clock cycles, moves one place, and bounces back whenever it reaches either end of the row. A pseudo-random generator also reverses the direction of travel now and then in the middle of the row, so the next position is hard to predict. Each position has its own push button. The player tries to press the button under the lit LED.

A press that lands on the lit position adds one point to a signed score. Any other press takes one point away. The score saturates at plus and minus 99. Only the first press in each step period counts. The score drives three seven-segment patterns: a minus-sign digit, a tens digit and a ones digit.

The buttons are asynchronous to the clock. Each button is synchronised and edge-detected before it reaches the scoring logic, so holding a button down counts as one press.

Top module: `target_catch`

## Requirements
- R1: After reset is released, the target moves by exactly one position at every step. A step falls every STEP_CYCLES clock cycles, and the first step comes on the STEP_CYCLES-th rising edge after reset is released.
- R2: Exactly one bit of `led_o` is high at all times, and `led_o[i]` marks position i. Reset places the target at position 0, travelling upward (toward higher indices).
- R3: Between steps the lit position does not change.
- R4: At a step taken from position 0 the target always moves to 1. At a step taken from position N_POS-1 it always moves to N_POS-2. A random flip has no effect at either end.
- R5: The random source is a 16-bit shift register. It is seeded with 0xACE1 at reset. At every step it shifts left by one, and the bit shifted in is the XOR of state bits 15, 13, 12 and 10. At a step taken from an inner position, the direction reverses before the move when bits [2:0] of the state before that shift are all zero.
- R6: A press is a 0-to-1 transition on a button after two synchronising flops. It is judged at the third rising clock edge after the button goes high, against the position held just before that edge. If the button of that position is among the risen buttons, the score goes up by 1. Otherwise it goes down by 1.
- R7: The score never rises above +99 or falls below -99. A hit at +99 and a miss at -99 leave it unchanged.
- R8: Only the first press of a step is scored, and later presses in the same step are ignored. Every step re-arms scoring. A press judged on the same edge as a step is scored against the position being left, and the next press after that step is scored again.
- R9: Segment patterns are active-high with bit order {g,f,e,d,c,b,a}. The digit codes 0..9 are 3F,06,5B,4F,66,6D,7D,07,7F,6F. The sign pattern is 40 (segment g) for a negative score and 00 otherwise. The tens digit is always shown, including a leading zero.
- R10: During and right after reset, the score is 0 and the display shows a blank sign and "00".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_i | input | N_POS | Raw push buttons, one per position, high while pressed |
| led_o | output | N_POS | One-hot lit target position |
| seg_sign_o | output | 7 | Sign digit segments |
| seg_tens_o | output | 7 | Tens digit segments |
| seg_ones_o | output | 7 | Ones digit segments |

## Verification
Two functions can land on the same clock edge: judging a press, and the step that moves the target and re-arms scoring. The bench tracks the step phase and raises a button exactly three cycles before a step edge. It then expects the point to be awarded against the position being left, and it expects the next press, made in the new step, to be scored as well. A second press inside an already-scored step is also driven, and the bench expects it to leave the score unchanged.

// File: rtl/tc_pkg.sv
package tc_pkg;

   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } tc_dir_e;

   localparam logic [6:0] TC_SEG_MINUS = 7'h40;
   localparam logic [6:0] TC_SEG_BLANK = 7'h00;

   // digit to active-high pattern, bit order {g,f,e,d,c,b,a}
   function automatic logic [6:0] tc_digit_segs(input logic [3:0] d);
      logic [6:0] s;
      case (d)
         4'd0:    s = 7'h3F;
         4'd1:    s = 7'h06;
         4'd2:    s = 7'h5B;
         4'd3:    s = 7'h4F;
         4'd4:    s = 7'h66;
         4'd5:    s = 7'h6D;
         4'd6:    s = 7'h7D;
         4'd7:    s = 7'h07;
         4'd8:    s = 7'h7F;
         4'd9:    s = 7'h6F;
         default: s = 7'h00;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/tc_step_timer.sv
module tc_step_timer #(
   parameter int STEP_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic step_o
);
   localparam int CNT_W = $clog2(STEP_CYCLES);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEP_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   assign step_o = (cnt_q == LAST_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (step_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/tc_lfsr.sv
module tc_lfsr #(
   parameter int              WIDTH     = 16,
   parameter logic [WIDTH-1:0] TAPS     = 16'hB400,
   parameter logic [WIDTH-1:0] SEED     = 16'hACE1,
   parameter int              TEST_BITS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv_i,
   output logic flip_o
);
   logic [WIDTH-1:0] state_q;
   logic             fb;

   assign fb     = ^(state_q & TAPS);
   assign flip_o = (state_q[TEST_BITS-1:0] == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     state_q <= SEED;
      else if (adv_i) state_q <= {state_q[WIDTH-2:0], fb};
   end
endmodule

// File: rtl/tc_mover.sv
module tc_mover
   import tc_pkg::*;
#(
   parameter int N_POS = 8,
   parameter int POS_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             flip_i,
   output logic [POS_W-1:0] pos_o,
   output logic [N_POS-1:0] led_o
);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(N_POS - 1);

   logic [POS_W-1:0] pos_q;
   tc_dir_e          dir_q, dir_n;

   always_comb begin
      dir_n = dir_q;
      if (pos_q == '0)          dir_n = DIR_UP;
      else if (pos_q == LAST_POS) dir_n = DIR_DOWN;
      else if (flip_i)          dir_n = (dir_q == DIR_UP) ? DIR_DOWN : DIR_UP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
         dir_q <= DIR_UP;
      end else if (step_i) begin
         dir_q <= dir_n;
         pos_q <= (dir_n == DIR_UP) ? pos_q + 1'b1 : pos_q - 1'b1;
      end
   end

   assign pos_o = pos_q;

   for (genvar i = 0; i < N_POS; i++) begin : g_led
      assign led_o[i] = (pos_q == POS_W'(i));
   end
endmodule

// File: rtl/tc_button_sync.sv
module tc_button_sync #(
   parameter int N_BTN  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_BTN-1:0] btn_i,
   output logic [N_BTN-1:0] rise_o
);
   logic [STAGES-1:0][N_BTN-1:0] chain_q;
   logic [N_BTN-1:0]             prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], btn_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tc_scorer.sv
module tc_scorer #(
   parameter int N_POS     = 8,
   parameter int POS_W     = 3,
   parameter int SCORE_W   = 8,
   parameter int SCORE_LIM = 99
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_POS-1:0]          rise_i,
   input  logic [POS_W-1:0]          pos_i,
   input  logic                      step_i,
   output logic signed [SCORE_W-1:0] score_o
);
   localparam logic signed [SCORE_W-1:0] TOP_V = SCORE_W'(SCORE_LIM);
   localparam logic signed [SCORE_W-1:0] BOT_V = SCORE_W'(-SCORE_LIM);

   logic signed [SCORE_W-1:0] score_q;
   logic                      taken_q;
   logic                      press, hit;

   assign press = |rise_i;
   assign hit   = rise_i[pos_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         score_q <= '0;
         taken_q <= 1'b0;
      end else begin
         if (press && !taken_q) begin
            if (hit) begin
               if (score_q != TOP_V) score_q <= score_q + 1'b1;
            end else if (score_q != BOT_V) begin
               score_q <= score_q - 1'b1;
            end
         end
         if (step_i)     taken_q <= 1'b0;
         else if (press) taken_q <= 1'b1;
      end
   end

   assign score_o = score_q;
endmodule

// File: rtl/tc_score_display.sv
module tc_score_display
   import tc_pkg::*;
#(
   parameter int SCORE_W        = 8,
   parameter bit SEG_ACTIVE_LOW = 1'b0
) (
   input  logic signed [SCORE_W-1:0] score_i,
   output logic [6:0]                seg_sign_o,
   output logic [6:0]                seg_tens_o,
   output logic [6:0]                seg_ones_o
);
   logic [3:0] tens_d, ones_d;
   logic [6:0] sign_raw, tens_raw, ones_raw;

   always_comb begin : p_split
      int mag;
      int tens;
      mag    = score_i[SCORE_W-1] ? -int'(score_i) : int'(score_i);
      tens   = mag / 10;
      tens_d = 4'(tens);
      ones_d = 4'(mag - tens * 10);
   end

   assign sign_raw = score_i[SCORE_W-1] ? TC_SEG_MINUS : TC_SEG_BLANK;
   assign tens_raw = tc_digit_segs(tens_d);
   assign ones_raw = tc_digit_segs(ones_d);

   if (SEG_ACTIVE_LOW) begin : g_low
      assign seg_sign_o = ~sign_raw;
      assign seg_tens_o = ~tens_raw;
      assign seg_ones_o = ~ones_raw;
   end else begin : g_high
      assign seg_sign_o = sign_raw;
      assign seg_tens_o = tens_raw;
      assign seg_ones_o = ones_raw;
   end
endmodule

// File: rtl/target_catch.sv
module target_catch #(
   parameter int              N_POS          = 8,
   parameter int              STEP_CYCLES    = 12_500_000,
   parameter int              LFSR_W         = 16,
   parameter logic [LFSR_W-1:0] LFSR_TAPS    = 16'hB400,
   parameter logic [LFSR_W-1:0] LFSR_SEED    = 16'hACE1,
   parameter int              FLIP_BITS      = 3,
   parameter int              SYNC_STAGES    = 2,
   parameter int              SCORE_W        = 8,
   parameter int              SCORE_LIM      = 99,
   parameter bit              SEG_ACTIVE_LOW = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_POS-1:0] btn_i,
   output logic [N_POS-1:0] led_o,
   output logic [6:0]       seg_sign_o,
   output logic [6:0]       seg_tens_o,
   output logic [6:0]       seg_ones_o
);
   localparam int POS_W = $clog2(N_POS);

   if (N_POS < 3)                        begin : g_bad_pos   $error("N_POS must be at least 3"); end
   if (STEP_CYCLES < 4)                  begin : g_bad_step  $error("STEP_CYCLES must be at least 4"); end
   if (SYNC_STAGES < 2)                  begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
   if (FLIP_BITS < 1 || FLIP_BITS >= LFSR_W) begin : g_bad_flip $error("FLIP_BITS out of range"); end
   if (LFSR_SEED == '0)                  begin : g_bad_seed  $error("LFSR_SEED must be nonzero"); end
   if (SCORE_LIM > 99)                   begin : g_bad_lim   $error("SCORE_LIM exceeds two digits"); end
   if (SCORE_LIM >= (1 << (SCORE_W - 1))) begin : g_bad_sw   $error("SCORE_W too narrow for SCORE_LIM"); end

   logic                      step_w;
   logic                      flip_w;
   logic [POS_W-1:0]          pos_w;
   logic [N_POS-1:0]          rise_w;
   logic signed [SCORE_W-1:0] score_w;

   tc_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .step_o(step_w));

   tc_lfsr #(.WIDTH(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED), .TEST_BITS(FLIP_BITS)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .adv_i(step_w), .flip_o(flip_w));

   tc_mover #(.N_POS(N_POS), .POS_W(POS_W)) u_mover (
      .clk(clk), .rst_n(rst_n), .step_i(step_w), .flip_i(flip_w),
      .pos_o(pos_w), .led_o(led_o));

   tc_button_sync #(.N_BTN(N_POS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .btn_i(btn_i), .rise_o(rise_w));

   tc_scorer #(.N_POS(N_POS), .POS_W(POS_W), .SCORE_W(SCORE_W), .SCORE_LIM(SCORE_LIM)) u_score (
      .clk(clk), .rst_n(rst_n), .rise_i(rise_w), .pos_i(pos_w), .step_i(step_w),
      .score_o(score_w));

   tc_score_display #(.SCORE_W(SCORE_W), .SEG_ACTIVE_LOW(SEG_ACTIVE_LOW)) u_disp (
      .score_i(score_w), .seg_sign_o(seg_sign_o), .seg_tens_o(seg_tens_o), .seg_ones_o(seg_ones_o));
endmodule

// File: rtl/target_catch_checker.sv
module target_catch_checker #(
   parameter int N_POS     = 8,
   parameter int SCORE_W   = 8,
   parameter int SCORE_LIM = 99
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      step,
   input logic [N_POS-1:0]          leds,
   input logic signed [SCORE_W-1:0] score
);
   localparam logic signed [SCORE_W-1:0] LIM_HI = SCORE_W'(SCORE_LIM);
   localparam logic signed [SCORE_W-1:0] LIM_LO = SCORE_W'(-SCORE_LIM);
   localparam logic signed [SCORE_W-1:0] ONE    = SCORE_W'(1);

   logic live_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= 1'b1;
   end

   AST_ONE_LED_LIT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(leds) == 1); // R2

   AST_MOVE_ONE_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(step)) |->
         (leds == ($past(leds) << 1) || leds == ($past(leds) >> 1))); // R1

   AST_HOLD_BETWEEN_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && !$past(step)) |-> $stable(leds)); // R3

   AST_BOUNCE_LOW_END: assert property (@(posedge clk) disable iff (!rst_n)
      (step && leds[0]) |=> leds[1]); // R4

   AST_BOUNCE_HIGH_END: assert property (@(posedge clk) disable iff (!rst_n)
      (step && leds[N_POS-1]) |=> leds[N_POS-2]); // R4

   AST_SCORE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (score <= LIM_HI) && (score >= LIM_LO)); // R7

   AST_SCORE_UNIT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      live_q |-> (score == $past(score) || score == $past(score) + ONE
                  || score == $past(score) - ONE)); // R6
endmodule

bind target_catch target_catch_checker #(
   .N_POS(N_POS), .SCORE_W(SCORE_W), .SCORE_LIM(SCORE_LIM)
) u_chk (
   .clk(clk), .rst_n(rst_n), .step(step_w), .leds(led_o), .score(score_w)
);

// File: tb/target_catch_test.sv
`timescale 1ns/1ps
module target_catch_test;
   localparam int NP = 8;
   localparam int S  = 16;

   logic          clk   = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] btn   = '0;
   logic [NP-1:0] led;
   logic [6:0]    seg_s, seg_t, seg_o;

   target_catch #(.N_POS(NP), .STEP_CYCLES(S)) uut (
      .clk(clk), .rst_n(rst_n), .btn_i(btn), .led_o(led),
      .seg_sign_o(seg_s), .seg_tens_o(seg_t), .seg_ones_o(seg_o));

   always #2 clk = ~clk;

   int          checks = 0, fails = 0;
   int          phase = -1, m_pos = 0, exp_score = 0;
   bit          m_up = 1'b1, running = 1'b0;
   logic [15:0] m_lfsr = 16'hACE1;
   event        tick_ev;

   function automatic logic [6:0] dig(int d);
      case (d)
         0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
         4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
         8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
      endcase
   endfunction

   function automatic logic [20:0] exp_disp(int sc);
      int m;
      m = (sc < 0) ? -sc : sc;
      return {(sc < 0) ? 7'h40 : 7'h00, dig(m / 10), dig(m % 10)};
   endfunction

   task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   task automatic check_disp(string req, string what);
      check({seg_s, seg_t, seg_o} == exp_disp(exp_score), req, what,
            32'({seg_s, seg_t, seg_o}), 32'(exp_disp(exp_score)));
   endtask

   task automatic model_step();
      bit flip;
      flip = (m_lfsr[2:0] == 3'b000);
      if (m_pos == 0)           m_up = 1'b1;
      else if (m_pos == NP - 1) m_up = 1'b0;
      else if (flip)            m_up = !m_up;
      m_pos  = m_up ? m_pos + 1 : m_pos - 1;
      m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
   endtask

   // position monitor: R1 R4 R5 after each step, R3 mid-step
   always @(negedge clk) begin
      if (running) begin
         phase++;
         if (phase == S) begin
            phase = 0;
            model_step();
            check(led == (NP'(1) << m_pos), "R1 R4 R5", "position after step",
                  32'(led), 32'(NP'(1) << m_pos));
         end else if (phase == S / 2) begin
            check(led == (NP'(1) << m_pos), "R3", "position mid-step",
                  32'(led), 32'(NP'(1) << m_pos));
         end
         -> tick_ev;
      end
   end

   // mode: 0 hit, 1 miss, 2 hit with a second button
   task automatic press(int mode, bit collide, bit same_step, bit counts, string req);
      int b;
      if (!same_step) begin
         do @(tick_ev); while (phase != 0);
      end
      if (collide)        while (phase != S - 3) @(tick_ev);
      else if (same_step) while (phase != 6) @(tick_ev);
      b = (mode == 1) ? (m_pos + 3) % NP : m_pos;
      btn = NP'(1) << b;
      if (mode == 2) btn = btn | (NP'(1) << ((m_pos + 5) % NP));
      @(tick_ev); @(tick_ev);
      check_disp(req, "score moved before third edge");
      @(tick_ev);
      if (counts) begin
         if (mode != 1) exp_score = (exp_score < 99) ? exp_score + 1 : 99;
         else           exp_score = (exp_score > -99) ? exp_score - 1 : -99;
      end
      check_disp(req, "score after press");
      btn = '0;
      repeat (3) @(tick_ev);
   endtask

   task automatic test_reset();
      #1;
      check(led == NP'(1), "R2", "reset position", 32'(led), 32'(1));
      check_disp("R10", "reset display");
      @(posedge clk); #1;
      rst_n = 1'b1; running = 1'b1;
      @(tick_ev);
      check(led == NP'(1), "R2", "position after release", 32'(led), 32'(1));
      check_disp("R9", "zero display");
   endtask

   task automatic test_sweep();
      repeat (50 * S) @(tick_ev);
   endtask

   task automatic test_hits_and_misses();
      repeat (5) press(0, 1'b0, 1'b0, 1'b1, "R6 R9");
      repeat (8) press(1, 1'b0, 1'b0, 1'b1, "R6 R9");
      press(2, 1'b0, 1'b0, 1'b1, "R6");
   endtask

   task automatic test_one_per_step();
      press(0, 1'b0, 1'b0, 1'b1, "R8");
      press(0, 1'b0, 1'b1, 1'b0, "R8");
      press(1, 1'b0, 1'b0, 1'b1, "R8");
      press(0, 1'b0, 1'b1, 1'b0, "R8");
   endtask

   task automatic test_collision();
      press(0, 1'b1, 1'b0, 1'b1, "R8");
      press(0, 1'b0, 1'b1, 1'b1, "R8");
      press(1, 1'b1, 1'b0, 1'b1, "R8");
   endtask

   task automatic test_saturation();
      while (exp_score < 99) press(0, 1'b0, 1'b0, 1'b1, "R7");
      repeat (3) press(0, 1'b0, 1'b0, 1'b1, "R7");
      while (exp_score > -99) press(1, 1'b0, 1'b0, 1'b1, "R7");
      repeat (3) press(1, 1'b0, 1'b0, 1'b1, "R7");
      press(0, 1'b0, 1'b0, 1'b1, "R7");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      test_sweep();
      test_hits_and_misses();
      test_one_per_step();
      test_collision();
      test_saturation();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(4 * 190000);
      fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule